// File: doc/BRIEF.md
# Direct-Access Command Gate with File Mask and Seek Check

This block sits in front of a direct-access device controller and judges every command of a channel chain before the device acts on it. It holds a one-byte file mask per chain. The mask is cleared when a new chain begins and may be loaded once by a set-file-mask command. The mask decides which classes of write and seek the chain may issue. Each command is either accepted or rejected with unit check.

Seek commands carry a six-byte argument. The block checks that argument fully: the filler bytes must be zero and the cylinder and head must lie within the device. A seek that is accepted moves the reported access position. The full seek sets both cylinder and head. A cylinder-only seek sets only the cylinder, and a head-only seek sets only the head. Searches, reads, data transfer and timing are left to other blocks. Any command the gate does not classify passes through and is accepted.

Commands enter on a valid/ready handshake and are taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high in every cycle except one in which `chain_start` is asserted. A source that sees `cmd_ready` low must hold its command and valid until a later cycle. Results leave as one-cycle pulses with no back-pressure.

Top module: `dasd_cmd_gate`

## Requirements
- R1: After reset, `res_accept` and `res_ucheck` are low, `cyl_pos` and `head_pos` are 0, and `cmd_ready` is high.
- R2: A cycle with `chain_start` high takes no command (`cmd_ready` low), clears the mask to 0x00 and re-arms the single set-file-mask load. The position is kept.
- R3: Set-file-mask (opcode 0x1F) takes its mask from the first argument byte, `cmd_arg[47:40]`. Mask bits are numbered with MSB as bit 0. If bit 2, bit 3 or bit 6 is 1, the command gets unit check and the mask is left unchanged; a later set-file-mask in the same chain may still load.
- R4: Once a set-file-mask has been accepted in a chain, any further set-file-mask in that chain gets unit check.
- R5: Mask bits 0..1 set the write class. 00 rejects write R0 (0x15). 01 rejects every write (0x05, 0x0D, 0x15, 0x1D). 10 rejects the format writes 0x15 and 0x1D. 11 accepts all writes.
- R6: Mask bits 3..5 set the seek class. 000 accepts seek (0x07), seek cylinder (0x08) and seek head (0x18). 001 accepts only 0x08 and 0x18. 010 accepts only 0x18. 011 rejects all three.
- R7: A seek argument is read as bytes B0..B5 from `cmd_arg[47:40]` down to `cmd_arg[7:0]`. Unit check results if B0, B1, B2 or B4 is nonzero, if the cylinder B3 is not below NCYL, or if the head B5 is not below NHEAD. This applies to all three seek variants.
- R8: A seek with `cmd_count` below 6 gets unit check. A count of 6 or more is valid, and only the first six bytes are used.
- R9: An accepted 0x07 sets both cylinder and head. An accepted 0x08 sets only the cylinder, and an accepted 0x18 sets only the head. A rejected command leaves the position unchanged.
- R10: Opcodes other than the seeks, writes and set-file-mask listed above are accepted whatever the mask.
- R11: In the cycle after each accepted handshake, exactly one of `res_accept` or `res_ucheck` pulses high for one cycle. Neither pulses at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_start | input | 1 | Marks the start of a new chain |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_count | input | CNT_W | Byte count of the command |
| cmd_arg | input | 48 | First six argument bytes, first byte in the top bits |
| res_accept | output | 1 | Command accepted (one-cycle pulse) |
| res_ucheck | output | 1 | Command rejected with unit check (one-cycle pulse) |
| cyl_pos | output | CYL_W | Current cylinder |
| head_pos | output | HEAD_W | Current head |

## Verification
The bench builds the gate with NCYL = 5 and NHEAD = 3. With limits this small, a sweep of cylinder and head values two past each limit covers both sides of every range boundary in a few dozen seeks. The same configuration allows all 256 mask bytes to be tried, each in its own chain. For every legal mask the bench issues each write and seek variant plus an unclassified opcode. It also tries the mask as a second set-file-mask in the same chain. For every illegal mask it confirms that the old mask still governs the chain.

// File: rtl/dasd_gate_pkg.sv
package dasd_gate_pkg;

  localparam logic [7:0] OP_SEEK      = 8'h07;
  localparam logic [7:0] OP_SEEK_CYL  = 8'h08;
  localparam logic [7:0] OP_SEEK_HEAD = 8'h18;
  localparam logic [7:0] OP_SET_MASK  = 8'h1F;
  localparam logic [7:0] OP_WR_R0     = 8'h15;
  localparam logic [7:0] OP_WR_CKD    = 8'h1D;
  localparam logic [7:0] OP_WR_DATA   = 8'h05;
  localparam logic [7:0] OP_WR_KD     = 8'h0D;

  localparam int ARG_BYTES = 6;
  localparam int SEEK_MIN_COUNT = 6;

  typedef enum logic [1:0] {
    WCLS_NO_R0  = 2'b00,
    WCLS_NONE   = 2'b01,
    WCLS_NO_FMT = 2'b10,
    WCLS_ALL    = 2'b11
  } wr_class_e;

  typedef enum logic [2:0] {
    SCLS_ALL     = 3'b000,
    SCLS_CYL_HD  = 3'b001,
    SCLS_HD_ONLY = 3'b010,
    SCLS_NONE    = 3'b011
  } seek_class_e;

  typedef struct packed {
    logic seek_full;
    logic seek_cyl;
    logic seek_head;
    logic set_mask;
    logic wr_r0;
    logic wr_ckd;
    logic wr_plain;
  } op_kind_t;

  function automatic op_kind_t classify_op(input logic [7:0] op);
    op_kind_t k;
    k.seek_full = (op == OP_SEEK);
    k.seek_cyl  = (op == OP_SEEK_CYL);
    k.seek_head = (op == OP_SEEK_HEAD);
    k.set_mask  = (op == OP_SET_MASK);
    k.wr_r0     = (op == OP_WR_R0);
    k.wr_ckd    = (op == OP_WR_CKD);
    k.wr_plain  = (op == OP_WR_DATA) || (op == OP_WR_KD);
    return k;
  endfunction

endpackage

// File: rtl/dasd_mask_decode.sv
module dasd_mask_decode
  import dasd_gate_pkg::*;
(
  input  logic [7:0]  mask,
  output logic        legal,
  output wr_class_e   wr_cls,
  output seek_class_e seek_cls
);
  // Bit k counted from the MSB sits at mask[7-k].
  logic rsv_b2, rsv_b3, rsv_b6;

  always_comb begin
    rsv_b2   = mask[5];
    rsv_b3   = mask[4];
    rsv_b6   = mask[1];
    legal    = !(rsv_b2 || rsv_b3 || rsv_b6);
    wr_cls   = wr_class_e'(mask[7:6]);
    seek_cls = seek_class_e'(mask[4:2]);
  end
endmodule

// File: rtl/dasd_mask_store.sv
module dasd_mask_store #(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [MASK_W-1:0] load_val,
  output logic [MASK_W-1:0] mask_q,
  output logic              used_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      used_q <= 1'b0;
    end else if (clr) begin
      mask_q <= '0;
      used_q <= 1'b0;
    end else if (load) begin
      mask_q <= load_val;
      used_q <= 1'b1;
    end
  end

  // R2
  mask_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (mask_q == '0 && !used_q));

  // R4
  used_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q && !clr) |=> used_q);

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> $stable(mask_q));
endmodule

// File: rtl/dasd_seek_arg_chk.sv
module dasd_seek_arg_chk
  import dasd_gate_pkg::*;
#(
  parameter int NCYL   = 20,
  parameter int NHEAD  = 4,
  parameter int CNT_W  = 16,
  parameter int CYL_W  = 5,
  parameter int HEAD_W = 2
) (
  input  logic [8*ARG_BYTES-1:0] arg,
  input  logic [CNT_W-1:0]       count,
  output logic                   arg_ok,
  output logic [CYL_W-1:0]       cyl,
  output logic [HEAD_W-1:0]      head
);
  localparam int CYL_IDX  = 3;
  localparam int HEAD_IDX = 5;

  logic [7:0] abyte [ARG_BYTES];
  logic [ARG_BYTES-1:0] byte_nz;

  for (genvar i = 0; i < ARG_BYTES; i++) begin : g_bytes
    assign abyte[i]   = arg[8*(ARG_BYTES-i)-1 -: 8];
    assign byte_nz[i] = (abyte[i] != 8'h00) && (i != CYL_IDX) && (i != HEAD_IDX);
  end

  logic filler_ok, cyl_ok, head_ok, cnt_ok;

  always_comb begin
    filler_ok = (byte_nz == '0);
    cyl_ok    = (int'(abyte[CYL_IDX]) < NCYL);
    head_ok   = (int'(abyte[HEAD_IDX]) < NHEAD);
    cnt_ok    = (count >= CNT_W'(SEEK_MIN_COUNT));
    arg_ok    = filler_ok && cyl_ok && head_ok && cnt_ok;
    cyl       = abyte[CYL_IDX][CYL_W-1:0];
    head      = abyte[HEAD_IDX][HEAD_W-1:0];
  end
endmodule

// File: rtl/dasd_cmd_gate.sv
module dasd_cmd_gate
  import dasd_gate_pkg::*;
#(
  parameter int NCYL  = 20,
  parameter int NHEAD = 4,
  parameter int CNT_W = 16,
  localparam int CYL_W  = (NCYL  > 1) ? $clog2(NCYL)  : 1,
  localparam int HEAD_W = (NHEAD > 1) ? $clog2(NHEAD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chain_start,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [47:0]       cmd_arg,
  output logic              res_accept,
  output logic              res_ucheck,
  output logic [CYL_W-1:0]  cyl_pos,
  output logic [HEAD_W-1:0] head_pos
);
  logic take;
  op_kind_t kind;

  logic [7:0]  mask_q;
  logic        mask_used;
  logic        cur_legal, new_legal;
  wr_class_e   cur_wr, new_wr;
  seek_class_e cur_sk, new_sk;

  logic              arg_ok;
  logic [CYL_W-1:0]  arg_cyl;
  logic [HEAD_W-1:0] arg_head;

  logic is_seek, is_write, write_ok, seek_perm, cmd_ok, mask_load;

  assign cmd_ready = !chain_start;
  assign take      = cmd_valid && cmd_ready;
  assign kind      = classify_op(cmd_op);

  dasd_mask_store #(.MASK_W(8)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (chain_start),
    .load     (mask_load),
    .load_val (cmd_arg[47:40]),
    .mask_q   (mask_q),
    .used_q   (mask_used)
  );

  dasd_mask_decode cur_dec_i (
    .mask     (mask_q),
    .legal    (cur_legal),
    .wr_cls   (cur_wr),
    .seek_cls (cur_sk)
  );

  dasd_mask_decode new_dec_i (
    .mask     (cmd_arg[47:40]),
    .legal    (new_legal),
    .wr_cls   (new_wr),
    .seek_cls (new_sk)
  );

  dasd_seek_arg_chk #(
    .NCYL   (NCYL),
    .NHEAD  (NHEAD),
    .CNT_W  (CNT_W),
    .CYL_W  (CYL_W),
    .HEAD_W (HEAD_W)
  ) seek_i (
    .arg    (cmd_arg),
    .count  (cmd_count),
    .arg_ok (arg_ok),
    .cyl    (arg_cyl),
    .head   (arg_head)
  );

  always_comb begin
    is_seek  = kind.seek_full || kind.seek_cyl || kind.seek_head;
    is_write = kind.wr_r0 || kind.wr_ckd || kind.wr_plain;

    unique case (cur_wr)
      WCLS_NO_R0:  write_ok = !kind.wr_r0;
      WCLS_NONE:   write_ok = !is_write;
      WCLS_NO_FMT: write_ok = !(kind.wr_r0 || kind.wr_ckd);
      default:     write_ok = 1'b1;
    endcase

    case (cur_sk)
      SCLS_ALL:     seek_perm = 1'b1;
      SCLS_CYL_HD:  seek_perm = kind.seek_cyl || kind.seek_head;
      SCLS_HD_ONLY: seek_perm = kind.seek_head;
      default:      seek_perm = 1'b0;
    endcase

    if (kind.set_mask)   cmd_ok = new_legal && !mask_used;
    else if (is_seek)    cmd_ok = arg_ok && seek_perm;
    else if (is_write)   cmd_ok = write_ok;
    else                 cmd_ok = 1'b1;

    mask_load = take && kind.set_mask && cmd_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_accept <= 1'b0;
      res_ucheck <= 1'b0;
      cyl_pos    <= '0;
      head_pos   <= '0;
    end else begin
      res_accept <= take && cmd_ok;
      res_ucheck <= take && !cmd_ok;
      if (take && cmd_ok && (kind.seek_full || kind.seek_cyl)) cyl_pos  <= arg_cyl;
      if (take && cmd_ok && (kind.seek_full || kind.seek_head)) head_pos <= arg_head;
    end
  end

  // R11
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_accept && res_ucheck));

  // R11
  result_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_accept || res_ucheck) |-> $past(cmd_valid && !chain_start));

  // R9
  reject_holds_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ucheck |-> ($stable(cyl_pos) && $stable(head_pos)));

  // R7
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cyl_pos) < NCYL) && (int'(head_pos) < NHEAD));

  // R3
  loaded_mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_legal);
endmodule

// File: tb/dasd_cmd_gate_tb_top.sv
`timescale 1ns/1ps
module dasd_cmd_gate_tb_top;
  localparam int NCYL  = 5;
  localparam int NHEAD = 3;
  localparam int CNT_W = 16;
  localparam int CYL_W  = 3;
  localparam int HEAD_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chain_start = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_op = 8'h00;
  logic [CNT_W-1:0] cmd_count = '0;
  logic [47:0] cmd_arg = '0;
  logic res_accept, res_ucheck;
  logic [CYL_W-1:0] cyl_pos;
  logic [HEAD_W-1:0] head_pos;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mdl_mask = 8'h00;
  bit mdl_used = 0;
  int mdl_cyl = 0;
  int mdl_head = 0;

  always #4 clk = ~clk;

  dasd_cmd_gate #(.NCYL(NCYL), .NHEAD(NHEAD), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .chain_start(chain_start),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_count(cmd_count), .cmd_arg(cmd_arg),
    .res_accept(res_accept), .res_ucheck(res_ucheck),
    .cyl_pos(cyl_pos), .head_pos(head_pos)
  );

  function automatic logic [47:0] seek_arg(input int c, input int h);
    return {8'h00, 8'h00, 8'h00, 8'(c), 8'h00, 8'(h)};
  endfunction

  function automatic bit mask_legal(input logic [7:0] m);
    return !(m[5] || m[4] || m[1]);
  endfunction

  function automatic bit model_ok(input logic [7:0] op, input int cnt, input logic [47:0] a);
    bit argv;
    logic [1:0] wc;
    logic [2:0] sk;
    wc = mdl_mask[7:6];
    sk = mdl_mask[4:2];
    argv = (a[47:24] == 24'h0) && (a[15:8] == 8'h00) && (int'(a[23:16]) < NCYL)
           && (int'(a[7:0]) < NHEAD) && (cnt >= 6);
    case (op)
      8'h1F: return mask_legal(a[47:40]) && !mdl_used;
      8'h07: return argv && (sk == 3'd0);
      8'h08: return argv && (sk == 3'd0 || sk == 3'd1);
      8'h18: return argv && (sk == 3'd0 || sk == 3'd1 || sk == 3'd2);
      8'h15: return (wc == 2'b11);
      8'h1D: return (wc == 2'b11) || (wc == 2'b00);
      8'h05, 8'h0D: return (wc != 2'b01);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic [7:0] op, input int cnt, input logic [47:0] a);
    bit e;
    e = model_ok(op, cnt, a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_count = cnt[CNT_W-1:0]; cmd_arg = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (e) begin
      if (op == 8'h1F) begin mdl_mask = a[47:40]; mdl_used = 1; end
      if (op == 8'h07 || op == 8'h08) mdl_cyl = int'(a[23:16]);
      if (op == 8'h07 || op == 8'h18) mdl_head = int'(a[7:0]);
    end
    check(tag, (res_accept == e) && (res_ucheck == !e), $sformatf("op %02h result accept", op),
          int'(res_accept), int'(e));
    check(tag, (int'(cyl_pos) == mdl_cyl) && (int'(head_pos) == mdl_head),
          $sformatf("op %02h position cyl*8+head", op),
          int'(cyl_pos) * 8 + int'(head_pos), mdl_cyl * 8 + mdl_head);
  endtask

  task automatic new_chain();
    @(negedge clk);
    chain_start = 1'b1;
    #1;
    // R2: no command taken while the chain starts
    check("R2", cmd_ready == 1'b0, "cmd_ready during chain_start", int'(cmd_ready), 0);
    @(negedge clk);
    chain_start = 1'b0;
    mdl_mask = 8'h00;
    mdl_used = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    if (!done) begin
      // wait for main flow
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] ops [8] = '{8'h05, 8'h0D, 8'h15, 8'h1D, 8'h07, 8'h08, 8'h18, 8'h06};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", !res_accept && !res_ucheck, "result pulses after reset",
          int'(res_accept) + int'(res_ucheck), 0);
    check("R1", cyl_pos == '0 && head_pos == '0, "position after reset",
          int'(cyl_pos) * 8 + int'(head_pos), 0);
    check("R1", cmd_ready == 1'b1, "cmd_ready after reset", int'(cmd_ready), 1);

    // R2: mask from previous chain does not survive a new chain
    new_chain();
    issue("R2", 8'h1F, 1, {8'hC0, 40'h0});
    issue("R2", 8'h15, 8, '0);
    new_chain();
    issue("R2", 8'h15, 8, '0);
    issue("R2", 8'h1D, 8, '0);

    // R3 R4 R5 R6 R10: every mask byte in its own chain
    for (int m = 0; m < 256; m++) begin
      new_chain();
      issue("R3", 8'h1F, 1, {8'(m), 40'h0});
      if (mask_legal(8'(m))) begin
        issue("R4", 8'h1F, 1, {8'hC0, 40'h0});
        for (int k = 0; k < 8; k++) begin
          issue((k < 4) ? "R5" : ((k < 7) ? "R6" : "R10"), ops[k], 6,
                seek_arg(m % NCYL, m % NHEAD));
        end
      end else begin
        issue("R3", 8'h15, 8, '0);
        issue("R3", 8'h1D, 8, '0);
        issue("R3", 8'h1F, 1, {8'hC0, 40'h0});
        issue("R3", 8'h15, 8, '0);
      end
    end

    // R7: cylinder and head limits, both sides of each boundary
    new_chain();
    for (int c = 0; c < NCYL + 2; c++) begin
      for (int h = 0; h < NHEAD + 2; h++) begin
        issue("R7", 8'h07, 6, seek_arg(c, h));
      end
    end
    // R7: nonzero filler bytes in each filler slot, all variants
    for (int v = 0; v < 3; v++) begin
      logic [7:0] sop;
      sop = (v == 0) ? 8'h07 : ((v == 1) ? 8'h08 : 8'h18);
      issue("R7", sop, 6, seek_arg(1, 1) | 48'h01_00_00_00_00_00);
      issue("R7", sop, 6, seek_arg(2, 1) | 48'h00_80_00_00_00_00);
      issue("R7", sop, 6, seek_arg(3, 2) | 48'h00_00_10_00_00_00);
      issue("R7", sop, 6, seek_arg(4, 0) | 48'h00_00_00_00_02_00);
      issue("R7", sop, 6, seek_arg(NCYL, 1));
      issue("R7", sop, 6, seek_arg(1, NHEAD));
    end

    // R8: seek count below, at and above six
    for (int n = 0; n < 10; n++) begin
      issue("R8", 8'h07, n, seek_arg(n % NCYL, n % NHEAD));
    end

    // R9: each variant touches only its own part of the position
    issue("R9", 8'h07, 6, seek_arg(1, 1));
    issue("R9", 8'h08, 6, seek_arg(4, 2));
    issue("R9", 8'h18, 6, seek_arg(0, 0));
    issue("R9", 8'h08, 6, seek_arg(2, NHEAD));
    issue("R9", 8'h18, 6, seek_arg(NCYL, 2));

    // R11: no pulse without a command
    repeat (2) @(negedge clk);
    check("R11", !res_accept && !res_ucheck, "idle result pulses",
          int'(res_accept) + int'(res_ucheck), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule